// File: doc/BRIEF.md
# Transmit Checksum Offload Engine

This block sits in the transmit path ahead of the MAC. Software prefixes each outgoing Ethernet frame with an 8-byte control header. The header holds the checksum enables, the position of the layer-3 header, the distance from there to the layer-4 header, and an optional pseudo-header partial sum. The block removes the control header and stores the frame in an internal buffer. While the bytes arrive it accumulates one's complement sums. After the last byte it writes an IPv4 header checksum and/or a TCP or UDP checksum into the buffered frame, then streams the modified frame out.

Header positions are not parsed from the frame. They come from the two offsets software places in the control header. The internal pseudo-header is built from the IPv4 source and destination addresses, the protocol byte and the IPv4 total length. It assumes a 20-byte IPv4 header with no options. Software can replace the internal pseudo-header with its own precomputed partial sum.

Both streams carry one byte per beat with valid/ready handshakes and start/end markers. The block takes input only while it is collecting a frame. It drives output only while it is emitting one.

Top module: `tx_csum_offload`

## Requirements
- R1: Of each input frame, the 8 control-header bytes are removed and the remaining bytes are emitted in order. `out_sof` is set on the first emitted byte only, and `out_eof` is set on the last one, after which `out_valid` drops.
- R2: When control byte 0 bit 0 (IP checksum enable) is set, the two bytes at layer-3 offset +10/+11 are replaced, most significant byte first, with the inverted one's complement sum. The sum covers the big-endian 16-bit words of the IPv4 header, whose length is four times the low nibble of its first byte, and counts the checksum field as zero. When the bit is clear those bytes pass unchanged.
- R3: When control byte 0 bit 1 (IP present) and bit 2 (layer-4 enable) are set and bit 3 (UDP) is clear, a TCP checksum is written at layer-4 offset +16/+17. It is the inverted one's complement sum of the pseudo-header and of every byte from the layer-4 start to the frame end. The checksum field counts as zero, and an odd trailing byte is padded with a low zero byte.
- R4: When bits 1, 2 and 3 are all set, the same computation is written at layer-4 offset +6/+7 as a UDP checksum. A computed value of 0x0000 is sent as 0xFFFF.
- R5: When bit 1 or bit 2 is clear, every layer-4 byte, including a zero UDP checksum field, passes unchanged.
- R6: Control byte 3 gives the layer-3 start, counted from the first frame byte after the control header. Control byte 2 gives the layer-4 start, counted from the layer-3 start.
- R7: When bit 4 (software pseudo-sum) is clear, the pseudo-header is formed from the 8 bytes at layer-3 offset +12..+19, the protocol byte at +9 (as a low byte), and the IPv4 total length (offset +2/+3) minus 20.
- R8: When bit 4 is set, the internal pseudo-header is skipped. Control bytes 4 (high) and 5 (low) are added instead as a 16-bit word.
- R9: Input is never accepted while the output stream is valid. No output is produced before the frame's last byte has been accepted.
- R10: Frame bytes beyond MAX_LEN are discarded. The emitted frame is then the first MAX_LEN bytes.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.
- R12: While `out_valid` is high and `out_ready` low, the output byte and markers hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Input byte (control header, then frame) |
| in_sof | input | 1 | First byte of a control header |
| in_eof | input | 1 | Last byte of the frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Output frame byte |
| out_sof | output | 1 | First byte of an output frame |
| out_eof | output | 1 | Last byte of an output frame |

## Verification
The assertions rely on three properties of the input. Every frame carries a complete 8-byte control header followed by at least one frame byte. The layer-4 start lies beyond the IPv4 address bytes. The downstream side eventually raises `out_ready`. The stimulus builds every frame from a generator that always emits the full header and a 20- or 24-byte IPv4 header with the layer-4 offset equal to that header length. It never stalls the output forever, because `out_ready` is withheld only on pseudo-random single cycles. Sweeps cover all 32 flag combinations at several layer-3 offsets and with odd and even layer-4 lengths. A directed frame forces the UDP sum to zero, and an oversized frame exercises truncation.

// File: rtl/txcso_pkg.sv
package txcso_pkg;

  localparam int CTL_BYTES = 8;
  localparam int ACC_W     = 32;

  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_LOAD = 2'd1,
    ST_FIN  = 2'd2,
    ST_OUT  = 2'd3
  } txcso_state_e;

  typedef struct packed {
    logic sw_psum;
    logic is_udp;
    logic l4_en;
    logic ip_there;
    logic ip_en;
  } txcso_flags_t;

  // End-around fold of a wide sum to 16 bits (no inversion)
  function automatic logic [15:0] fold32(input logic [ACC_W-1:0] a);
    logic [16:0] s1;
    logic [15:0] s2;
    s1 = {1'b0, a[15:0]} + {1'b0, a[31:16]};
    s2 = s1[15:0] + {15'b0, s1[16]};
    return s2;
  endfunction

endpackage

// File: rtl/txcso_csum_acc.sv
module txcso_csum_acc
  import txcso_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        byte_en,
  input  logic        byte_hi,
  input  logic [7:0]  byte_val,
  input  logic        word_en,
  input  logic [15:0] word_val,
  output logic [15:0] sum16
);

  logic [ACC_W-1:0] acc_q, acc_n;
  logic             acc_ce;

  always_comb begin
    acc_n = acc_q;
    if (clr) begin
      acc_n = '0;
    end else begin
      if (byte_en)
        acc_n = acc_n + (byte_hi ? {{(ACC_W-16){1'b0}}, byte_val, 8'h00}
                                 : {{(ACC_W-8){1'b0}}, byte_val});
      if (word_en)
        acc_n = acc_n + {{(ACC_W-16){1'b0}}, word_val};
    end
  end

  assign acc_ce = clr | byte_en | word_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_ce) acc_q <= acc_n;
  end

  assign sum16 = fold32(acc_q);

endmodule

// File: rtl/txcso_frame_buf.sv
module txcso_frame_buf #(
  parameter int DEPTH = 2048,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/tx_csum_offload.sv
module tx_csum_offload
  import txcso_pkg::*;
#(
  parameter int MAX_LEN = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof
);

  localparam int AW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
  localparam int IW = $clog2(MAX_LEN + 1);
  localparam int CW = (IW > 10) ? IW : 10;
  localparam logic [CW-1:0] MAX_C = CW'(MAX_LEN);

  // control state
  txcso_state_e state_q, state_n;
  logic [2:0]   hdr_cnt_q;
  txcso_flags_t flags_q;
  logic [7:0]   l3_q, l4o_q;
  logic [15:0]  psum_q;
  logic [CW-1:0] idx_q, len_q, rd_q;
  logic [5:0]   ihl_q;
  logic [15:0]  totlen_q;
  logic [2:0]   fin_q;

  // decode
  logic          in_fire, hdr_fire, load_fire, stor;
  logic [2:0]    hdr_pos;
  logic [CW-1:0] l3w, l4b, r3, r4;
  logic          at_l3, at_l4, ip_byte, ip_fld, l4_fld, ph_byte;
  logic          l4_on, last_out;

  assign in_ready  = (state_q == ST_HDR) || (state_q == ST_LOAD);
  assign in_fire   = in_valid && in_ready;
  assign hdr_fire  = in_fire && (state_q == ST_HDR);
  assign hdr_pos   = in_sof ? 3'd0 : hdr_cnt_q;
  assign stor      = idx_q < MAX_C;
  assign load_fire = in_fire && (state_q == ST_LOAD) && stor;

  assign l3w   = CW'(l3_q);
  assign l4b   = l3w + CW'(l4o_q);
  assign r3    = idx_q - l3w;
  assign r4    = idx_q - l4b;
  assign at_l3 = idx_q >= l3w;
  assign at_l4 = idx_q >= l4b;

  assign ip_byte = at_l3 && ((r3 == '0) || (r3 < CW'(ihl_q)));
  assign ip_fld  = (r3 == CW'(10)) || (r3 == CW'(11));
  assign l4_fld  = flags_q.is_udp ? ((r4 == CW'(6))  || (r4 == CW'(7)))
                                  : ((r4 == CW'(16)) || (r4 == CW'(17)));
  assign ph_byte = at_l3 && !at_l4 && !flags_q.sw_psum &&
                   ((r3 == CW'(9)) || ((r3 >= CW'(12)) && (r3 <= CW'(19))));
  assign l4_on   = flags_q.ip_there && flags_q.l4_en;

  // checksum accumulators
  logic [15:0] ip_sum, l4_sum, ip_cs, l4_raw, l4_cs, l4_word;
  logic        acc_clr, ip_ben, l4_ben, l4_bhi, l4_wen;

  assign acc_clr = (state_q == ST_HDR);
  assign ip_ben  = load_fire && ip_byte && !ip_fld;
  assign l4_ben  = load_fire && ((at_l4 && !l4_fld) || ph_byte);
  assign l4_bhi  = at_l4 ? ~r4[0] : ~r3[0];
  assign l4_wen  = (state_q == ST_FIN) && (fin_q == 3'd0);
  assign l4_word = flags_q.sw_psum ? psum_q : (totlen_q - 16'd20);

  txcso_csum_acc ip_acc_i (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr),
    .byte_en(ip_ben), .byte_hi(~r3[0]), .byte_val(in_data),
    .word_en(1'b0), .word_val(16'h0000), .sum16(ip_sum)
  );

  txcso_csum_acc l4_acc_i (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr),
    .byte_en(l4_ben), .byte_hi(l4_bhi), .byte_val(in_data),
    .word_en(l4_wen), .word_val(l4_word), .sum16(l4_sum)
  );

  assign ip_cs  = ~ip_sum;
  assign l4_raw = ~l4_sum;
  assign l4_cs  = (flags_q.is_udp && (l4_raw == 16'h0000)) ? 16'hFFFF : l4_raw;

  // buffer write port: frame bytes while loading, checksum bytes afterwards
  logic          buf_we, fin_we;
  logic [CW-1:0] fin_addr, fld_base;
  logic [7:0]    fin_data, buf_rdata;

  assign fld_base = l4b + (flags_q.is_udp ? CW'(6) : CW'(16));

  always_comb begin
    fin_we   = 1'b0;
    fin_addr = l3w + CW'(10);
    fin_data = ip_cs[15:8];
    unique case (fin_q)
      3'd1: begin fin_we = flags_q.ip_en; fin_addr = l3w + CW'(10);   fin_data = ip_cs[15:8]; end
      3'd2: begin fin_we = flags_q.ip_en; fin_addr = l3w + CW'(11);   fin_data = ip_cs[7:0];  end
      3'd3: begin fin_we = l4_on;         fin_addr = fld_base;        fin_data = l4_cs[15:8]; end
      3'd4: begin fin_we = l4_on;         fin_addr = fld_base + CW'(1); fin_data = l4_cs[7:0]; end
      default: fin_we = 1'b0;
    endcase
    if (fin_addr >= len_q) fin_we = 1'b0;
  end

  logic          is_fin;
  logic [CW-1:0] waddr_c;
  logic [7:0]    wdata_c;

  assign is_fin  = (state_q == ST_FIN);
  assign buf_we  = is_fin ? fin_we : load_fire;
  assign waddr_c = is_fin ? fin_addr : idx_q;
  assign wdata_c = is_fin ? fin_data : in_data;

  txcso_frame_buf #(.DEPTH(MAX_LEN), .DW(8)) buf_i (
    .clk(clk), .we(buf_we), .waddr(AW'(waddr_c)), .wdata(wdata_c),
    .raddr(AW'(rd_q)), .rdata(buf_rdata)
  );

  // output side
  assign last_out  = (rd_q == (len_q - CW'(1)));
  assign out_valid = (state_q == ST_OUT);
  assign out_data  = buf_rdata;
  assign out_sof   = out_valid && (rd_q == '0);
  assign out_eof   = out_valid && last_out;

  // next state
  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_HDR:  if (hdr_fire && !in_eof && (hdr_pos == 3'd7)) state_n = ST_LOAD;
      ST_LOAD: if (in_fire && in_eof) state_n = ST_FIN;
      ST_FIN:  if (fin_q == 3'd4) state_n = ST_OUT;
      ST_OUT:  if (out_ready && last_out) state_n = ST_HDR;
      default: state_n = ST_HDR;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_HDR;
      hdr_cnt_q <= 3'd0;
      flags_q   <= '0;
      l3_q      <= 8'd0;
      l4o_q     <= 8'd0;
      psum_q    <= 16'd0;
      idx_q     <= '0;
      len_q     <= '0;
      rd_q      <= '0;
      ihl_q     <= 6'd0;
      totlen_q  <= 16'd0;
      fin_q     <= 3'd0;
    end else begin
      state_q <= state_n;

      if (hdr_fire) begin
        hdr_cnt_q <= in_eof ? 3'd0 : hdr_pos + 3'd1;
        unique case (hdr_pos)
          3'd0: flags_q      <= txcso_flags_t'(in_data[4:0]);
          3'd2: l4o_q        <= in_data;
          3'd3: l3_q         <= in_data;
          3'd4: psum_q[15:8] <= in_data;
          3'd5: psum_q[7:0]  <= in_data;
          default: ;
        endcase
      end

      if (state_q == ST_HDR) idx_q <= '0;
      else if (load_fire)    idx_q <= idx_q + CW'(1);

      if (load_fire && at_l3 && (r3 == '0))      ihl_q          <= {in_data[3:0], 2'b00};
      if (load_fire && at_l3 && (r3 == CW'(2)))  totlen_q[15:8] <= in_data;
      if (load_fire && at_l3 && (r3 == CW'(3)))  totlen_q[7:0]  <= in_data;

      if ((state_q == ST_LOAD) && in_fire && in_eof)
        len_q <= stor ? idx_q + CW'(1) : idx_q;

      if (is_fin) fin_q <= fin_q + 3'd1;
      else        fin_q <= 3'd0;

      if (is_fin)                      rd_q <= '0;
      else if (out_valid && out_ready) rd_q <= rd_q + CW'(1);
    end
  end

endmodule

// File: rtl/txcso_chk.sv
module txcso_chk #(
  parameter int MAX_LEN = 2048
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sof,
  input logic       out_eof
);

  localparam int OW = $clog2(MAX_LEN + 1) + 1;

  logic [OW-1:0] ocnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                ocnt_q <= '0;
    else if (out_valid && out_ready && out_eof) ocnt_q <= '0;
    else if (out_valid && out_ready)            ocnt_q <= ocnt_q + OW'(1);
  end

  assert_ready_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)));

  assert_eof_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eof) |=> !out_valid);

  assert_sof_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_eof) |=> (out_valid && !out_sof));

  assert_trunc_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (ocnt_q < OW'(MAX_LEN)));

endmodule

bind tx_csum_offload txcso_chk #(.MAX_LEN(MAX_LEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof)
);

// File: tb/tx_csum_offload_tb_top.sv
module tx_csum_offload_tb_top;

  localparam int MAXL = 128;

  logic       clk;
  logic       rst_n;
  logic       in_valid, in_ready, in_sof, in_eof;
  logic [7:0] in_data;
  logic       out_valid, out_ready, out_sof, out_eof;
  logic [7:0] out_data;

  tx_csum_offload #(.MAX_LEN(MAXL)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int pay   [0:255];
  int hdr   [0:7];
  int exp_f [0:255];
  int rx    [0:511];
  int plen, elen, rlen;
  int mark_err, flow_err;
  int last_fold;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int fold(input int unsigned s);
    int unsigned t = s;
    while ((t >> 16) != 0) t = (t & 32'hFFFF) + (t >> 16);
    return int'(t);
  endfunction

  function automatic int unsigned osum(input int start, input int n);
    int unsigned s = 0;
    for (int i = 0; i < n; i++)
      s += ((i % 2) == 0) ? (exp_f[start+i] << 8) : exp_f[start+i];
    return s;
  endfunction

  task automatic make_frame(input int l3, input int ihlw, input int l4len,
                            input int proto, input int seed);
    int tl;
    int b;
    b  = l3;
    tl = ihlw * 4 + l4len;
    for (int i = 0; i < l3; i++) pay[i] = (i * 7 + seed) & 255;
    pay[b]    = 8'h40 | ihlw;
    pay[b+1]  = 0;
    pay[b+2]  = (tl >> 8) & 255;
    pay[b+3]  = tl & 255;
    for (int k = 4; k < 9; k++) pay[b+k] = (seed * 3 + k) & 255;
    pay[b+9]  = proto;
    pay[b+10] = 8'hA5;
    pay[b+11] = 8'h5A;
    for (int k = 12; k < ihlw * 4; k++) pay[b+k] = (k * 29 + seed) & 255;
    for (int k = 0; k < l4len; k++) pay[b+ihlw*4+k] = (k * 13 + seed * 5 + 1) & 255;
    plen = b + ihlw * 4 + l4len;
  endtask

  task automatic set_hdr(input int fl, input int l3, input int l4o, input int ps);
    hdr[0] = fl; hdr[1] = 0; hdr[2] = l4o; hdr[3] = l3;
    hdr[4] = (ps >> 8) & 255; hdr[5] = ps & 255; hdr[6] = 0; hdr[7] = 0;
  endtask

  // expected frame computed from the requirements (flag bits: 0 IP, 1 IP present, 2 L4, 3 UDP, 4 sw sum)
  task automatic model(input int fl, input int l3, input int l4o, input int ps);
    int unsigned s;
    int c, ihl, tl, b, fo;
    elen = (plen > MAXL) ? MAXL : plen;
    for (int i = 0; i < elen; i++) exp_f[i] = pay[i];
    ihl = (pay[l3] & 15) * 4;
    if ((fl & 1) != 0 && l3 + 11 < elen) begin
      exp_f[l3+10] = 0; exp_f[l3+11] = 0;
      c = (~fold(osum(l3, ihl))) & 16'hFFFF;
      exp_f[l3+10] = c >> 8; exp_f[l3+11] = c & 255;
    end
    if ((fl & 6) == 6) begin
      b  = l3 + l4o;
      fo = ((fl & 8) != 0) ? 6 : 16;
      exp_f[b+fo] = 0; exp_f[b+fo+1] = 0;
      s = osum(b, elen - b);
      if ((fl & 16) != 0) s += ps;
      else begin
        s += osum(l3 + 12, 8);
        s += pay[l3+9];
        tl = (pay[l3+2] << 8) | pay[l3+3];
        s += (tl - 20) & 16'hFFFF;
      end
      last_fold = fold(s);
      c = (~last_fold) & 16'hFFFF;
      if ((fl & 8) != 0 && c == 0) c = 16'hFFFF;
      exp_f[b+fo] = c >> 8; exp_f[b+fo+1] = c & 255;
    end
  endtask

  task automatic send_frame(input int total, input bit gaps);
    int k = 0;
    while (k < total) begin
      @(negedge clk);
      if (gaps && ($urandom % 4) == 0) begin
        in_valid = 1'b0;
      end else begin
        in_valid = 1'b1;
        in_data  = 8'((k < 8) ? hdr[k] : pay[k-8]);
        in_sof   = (k == 0);
        in_eof   = (k == total - 1);
        if (in_ready) k++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic recv_frame(input bit stall);
    bit done = 1'b0;
    rlen = 0;
    while (!done) begin
      @(negedge clk);
      out_ready = !(stall && ($urandom % 3) == 0);
      if (out_valid && in_ready) flow_err++;
      if (out_valid && out_ready) begin
        rx[rlen] = out_data;
        if (out_sof != (rlen == 0)) mark_err++;
        if (out_eof) done = 1'b1;
        rlen++;
      end
    end
  endtask

  task automatic run_and_compare(input bit gaps, input bit stall, input string tag);
    int bad = -1;
    mark_err = 0;
    fork
      send_frame(plen + 8, gaps);
      recv_frame(stall);
    join
    check(rlen == elen, {tag, " R1 length"}, rlen, elen);
    check(mark_err == 0, {tag, " R1 sof marker"}, mark_err, 0);
    for (int i = 0; i < elen && i < rlen; i++)
      if (bad < 0 && rx[i] != exp_f[i]) bad = i;
    check(bad < 0, {tag, " content"}, (bad < 0) ? 0 : rx[bad], (bad < 0) ? 0 : exp_f[bad]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int l3list [4] = '{0, 1, 14, 18};
    int w;
    string tag;
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    in_data = 8'h00; out_ready = 1'b0;
    flow_err = 0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R11 out_valid in reset", out_valid, 0);
    check(in_ready === 1'b1, "R11 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R11 idle after reset", out_valid, 0);

    // sweep over all flag combinations and several layer-3 offsets
    for (int li = 0; li < 4; li++) begin
      for (int fl = 0; fl < 32; fl++) begin
        int ihlw = (li == 3) ? 6 : 5;
        int ps   = (16'h1234 + fl * 97) & 16'hFFFF;
        make_frame(l3list[li], ihlw, 20 + (fl % 3), ((fl & 8) != 0) ? 17 : 6, fl + li);
        set_hdr(fl, l3list[li], ihlw * 4, ps);
        model(fl, l3list[li], ihlw * 4, ps);
        tag = "R6";
        if ((fl & 1) != 0) tag = {tag, " R2"};
        if ((fl & 6) == 6) begin
          tag = ((fl & 8) != 0) ? {tag, " R4"} : {tag, " R3"};
          tag = ((fl & 16) != 0) ? {tag, " R8"} : {tag, " R7"};
        end else begin
          tag = {tag, " R5"};
        end
        run_and_compare(fl[0], fl[1], tag);
      end
    end

    // UDP sum forced to zero must be sent as all ones
    make_frame(14, 5, 24, 17, 3);
    pay[plen-2] = 0; pay[plen-1] = 0;
    set_hdr(14, 14, 20, 0);
    model(14, 14, 20, 0);
    w = (~last_fold) & 16'hFFFF;
    pay[plen-2] = w >> 8; pay[plen-1] = w & 255;
    model(14, 14, 20, 0);
    run_and_compare(1'b0, 1'b1, "R4 zero-sum");
    check(rx[40] == 8'hFF && rx[41] == 8'hFF, "R4 zero sent as FFFF", (rx[40] << 8) | rx[41], 16'hFFFF);

    // oversized frame is truncated
    make_frame(0, 5, 130, 6, 9);
    set_hdr(0, 0, 20, 0);
    model(0, 0, 20, 0);
    run_and_compare(1'b1, 1'b1, "R10 truncation");

    check(flow_err == 0, "R9 input ready while output valid", flow_err, 0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule